// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM out of power-up. Once reset is released it holds the clock-enable low for a programmable settling period and then issues no-operation commands for a further programmable period. After that it raises the clock-enable and plays the fixed bring-up command train: precharge-all, the four mode-register loads, a second precharge-all, a programmable number of refreshes, the mode-register reload and the pair of driver-calibration writes. Each command is followed by its own minimum gap, and the sequencer issues no-operation commands throughout every gap. The contents of the four mode registers come in on input ports. The sequencer forces the bits that this sequence must control: the DLL-reset bit, the DLL-enable bit and the three calibration bits.

When the last gap has elapsed, the sequencer raises `init_done` and keeps issuing no-operation commands. A second flag, `read_allowed`, goes high only when `init_done` is high and enough clock cycles have passed since the DLL-reset load. Every gap is a cycle count set by a parameter. A synchronous reset returns the sequencer to the clock-enable-low settling state from any point in the sequence. All outputs are registered, so each output is one cycle behind the state that produces it.

States: `ST_PWR_WAIT` (CKE low, settling), `ST_NOP_WAIT` (CKE low, NOPs), `ST_PRE_FIRST`, `ST_LD_EMR2`, `ST_LD_EMR3`, `ST_LD_EMR_DLL`, `ST_LD_MR_RST`, `ST_PRE_SECOND`, `ST_REFRESH`, `ST_LD_MR`, `ST_LD_OCD_DFLT`, `ST_LD_OCD_EXIT`, `ST_GAP` (NOP countdown, then jump to the stored return state) and `ST_READY`.

Transitions:
- settling → NOP wait → first precharge.
- Each command state → `ST_GAP` when its gap exceeds one cycle, otherwise straight on to the next command.
- `ST_REFRESH` → `ST_REFRESH` until the last refresh, then → `ST_LD_MR`.
- OCD exit → `ST_READY`, which holds.
- Reset → `ST_PWR_WAIT` from every state.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, the outputs show cke=0, odt=0, command NOP, ba=0, addr=0, init_done=0 and read_allowed=0.
- R2: For PWR_CYC+NOP_CYC cycles after reset release, cke stays 0 and the command is NOP. After that cke is 1 and stays 1 until the next reset.
- R3: The first non-NOP command is PRECHARGE. It appears in the same cycle that cke first goes high, with addr bit 10 set and all other address bits and ba at 0.
- R4: The command encoding on {cs_n,ras_n,cas_n,we_n} is NOP=0111, PRECHARGE=0010, REFRESH=0001 and LOAD MODE=0000. The ba encoding is MR=00, EMR=01, EMR2=10 and EMR3=11. The non-NOP commands appear in this order: PRECHARGE, LOAD EMR2, LOAD EMR3, LOAD EMR, LOAD MR, PRECHARGE, REFRESH×REF_COUNT, LOAD MR, LOAD EMR, LOAD EMR.
- R5: The spacing from one command to the next is exactly RPA_CYC after a precharge, RFC_CYC after a refresh and MRD_CYC after a load.
- R6: EMR2 and EMR3 loads carry their configuration inputs unchanged. The first MR load carries mr_cfg with bit 8 (DLL reset) set. The second MR load carries mr_cfg with bit 8 cleared.
- R7: Every EMR load carries emr_cfg with bit 0 cleared, which enables the DLL. The first and third EMR loads have bits 9:7 at 000. The second EMR load (calibration default) has bits 9:7 at 111.
- R8: Exactly REF_COUNT REFRESH commands are issued, and they are not interleaved with any other command.
- R9: Every cycle between two commands, and every cycle after the sequence ends, carries NOP with ba=0 and addr=0.
- R10: init_done rises exactly MRD_CYC cycles after the final EMR load and stays high until reset.
- R11: read_allowed is high exactly when init_done is high and at least DLL_CYC cycles have passed since the DLL-reset MR load.
- R12: A reset asserted mid-sequence returns every output to the R1 state, and the full sequence restarts from the settling period.
- R13: odt is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_cfg | input | ROW_W | Mode register contents |
| emr_cfg | input | ROW_W | Extended mode register contents |
| emr2_cfg | input | ROW_W | EMR2 contents |
| emr3_cfg | input | ROW_W | EMR3 contents |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination control, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode register select |
| addr | output | ROW_W | Address / mode register payload |
| init_done | output | 1 | Initialization finished |
| read_allowed | output | 1 | Reads may be issued |

## Verification
The sequence is run twice from reset, with two configuration patterns. In the first, all configuration bits are set, which shows whether the sequencer clears the DLL-enable, DLL-reset and calibration bits where it must. In the second, the fields are sparse and differ from one register to the next, which shows whether the sequencer sets forced bits and passes every other bit through from the correct register. Between the two runs, a reset is applied in the middle of the refresh phase. This shows whether the restart is complete, including the refresh count and the DLL timer. The gap lengths are chosen so that init_done rises before the DLL wait ends, which separates the two conditions that read_allowed depends on.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_NOP_WAIT,
        ST_PRE_FIRST,
        ST_LD_EMR2,
        ST_LD_EMR3,
        ST_LD_EMR_DLL,
        ST_LD_MR_RST,
        ST_PRE_SECOND,
        ST_REFRESH,
        ST_LD_MR,
        ST_LD_OCD_DFLT,
        ST_LD_OCD_EXIT,
        ST_GAP,
        ST_READY
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PRE  = 4'b0010;
    localparam logic [3:0] CMD_REF  = 4'b0001;
    localparam logic [3:0] CMD_LOAD = 4'b0000;

    localparam logic [1:0] SEL_MR   = 2'b00;
    localparam logic [1:0] SEL_EMR  = 2'b01;
    localparam logic [1:0] SEL_EMR2 = 2'b10;
    localparam logic [1:0] SEL_EMR3 = 2'b11;

    localparam int BIT_DLL_OFF  = 0;
    localparam int BIT_OCD_LO   = 7;
    localparam int BIT_DLL_RST  = 8;
    localparam int BIT_ALL_BANK = 10;

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= CNT_W'(RST_VAL);
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);  // R5

endmodule

// File: rtl/ddr2_dll_timer.sv
module ddr2_dll_timer #(
    parameter int DLL_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic elapsed
);

    localparam int W = $clog2(DLL_CYC + 1);

    logic         armed;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (start) begin
            armed <= 1'b1;
            cnt   <= W'(DLL_CYC - 1);
        end else if (armed && cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign elapsed = armed && (cnt == '0);

    AST_DLL_STAYS_ELAPSED: assert property (@(posedge clk) disable iff (rst)
        (elapsed && !start) |=> elapsed);  // R11

endmodule

// File: rtl/ddr2_cmd_encode.sv
module ddr2_cmd_encode
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int BA_W  = 2
) (
    input  seq_state_e       state,
    input  logic [ROW_W-1:0] mr_cfg,
    input  logic [ROW_W-1:0] emr_cfg,
    input  logic [ROW_W-1:0] emr2_cfg,
    input  logic [ROW_W-1:0] emr3_cfg,
    output logic [3:0]       cmd,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr
);

    localparam logic [ROW_W-1:0] OCD_MASK = ROW_W'(3) << BIT_OCD_LO | ROW_W'(4) << BIT_OCD_LO;
    localparam logic [ROW_W-1:0] DLL_OFF  = ROW_W'(1) << BIT_DLL_OFF;
    localparam logic [ROW_W-1:0] DLL_RST  = ROW_W'(1) << BIT_DLL_RST;
    localparam logic [ROW_W-1:0] ALL_BANK = ROW_W'(1) << BIT_ALL_BANK;

    logic [ROW_W-1:0] emr_base;
    assign emr_base = emr_cfg & ~(OCD_MASK | DLL_OFF);

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_PRE_FIRST, ST_PRE_SECOND: begin
                cmd  = CMD_PRE;
                addr = ALL_BANK;
            end
            ST_REFRESH: cmd = CMD_REF;
            ST_LD_EMR2: begin
                cmd  = CMD_LOAD;
                ba   = BA_W'(SEL_EMR2);
                addr = emr2_cfg;
            end
            ST_LD_EMR3: begin
                cmd  = CMD_LOAD;
                ba   = BA_W'(SEL_EMR3);
                addr = emr3_cfg;
            end
            ST_LD_EMR_DLL, ST_LD_OCD_EXIT: begin
                cmd  = CMD_LOAD;
                ba   = BA_W'(SEL_EMR);
                addr = emr_base;
            end
            ST_LD_OCD_DFLT: begin
                cmd  = CMD_LOAD;
                ba   = BA_W'(SEL_EMR);
                addr = emr_base | OCD_MASK;
            end
            ST_LD_MR_RST: begin
                cmd  = CMD_LOAD;
                ba   = BA_W'(SEL_MR);
                addr = mr_cfg | DLL_RST;
            end
            ST_LD_MR: begin
                cmd  = CMD_LOAD;
                ba   = BA_W'(SEL_MR);
                addr = mr_cfg & ~DLL_RST;
            end
            ST_PWR_WAIT, ST_NOP_WAIT, ST_GAP, ST_READY: begin
                cmd  = CMD_NOP;
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W     = 14,
    parameter int BA_W      = 2,
    parameter int PWR_CYC   = 40000,
    parameter int NOP_CYC   = 80,
    parameter int RPA_CYC   = 5,
    parameter int MRD_CYC   = 2,
    parameter int RFC_CYC   = 35,
    parameter int DLL_CYC   = 200,
    parameter int REF_COUNT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] mr_cfg,
    input  logic [ROW_W-1:0] emr_cfg,
    input  logic [ROW_W-1:0] emr2_cfg,
    input  logic [ROW_W-1:0] emr3_cfg,
    output logic             cke,
    output logic             odt,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr,
    output logic             init_done,
    output logic             read_allowed
);

    localparam int MAX_A   = (PWR_CYC > NOP_CYC) ? PWR_CYC : NOP_CYC;
    localparam int MAX_B   = (RPA_CYC > RFC_CYC) ? RPA_CYC : RFC_CYC;
    localparam int MAX_C   = (MAX_B > MRD_CYC) ? MAX_B : MRD_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int RC_W    = $clog2(REF_COUNT + 1);

    seq_state_e       state, state_nxt, ret, ret_nxt;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic [RC_W-1:0]  ref_cnt;
    logic             dll_elapsed;
    logic [3:0]       enc_cmd;
    logic [BA_W-1:0]  enc_ba;
    logic [ROW_W-1:0] enc_addr;

    ddr2_init_timer #(.CNT_W(CNT_W), .RST_VAL(PWR_CYC - 1)) u_gap_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    ddr2_dll_timer #(.DLL_CYC(DLL_CYC)) u_dll_timer (
        .clk(clk), .rst(rst), .start(state == ST_LD_MR_RST), .elapsed(dll_elapsed)
    );

    ddr2_cmd_encode #(.ROW_W(ROW_W), .BA_W(BA_W)) u_encode (
        .state(state), .mr_cfg(mr_cfg), .emr_cfg(emr_cfg), .emr2_cfg(emr2_cfg),
        .emr3_cfg(emr3_cfg), .cmd(enc_cmd), .ba(enc_ba), .addr(enc_addr)
    );

    // next-state logic
    always_comb begin
        logic       is_cmd;
        seq_state_e tgt;
        int         gap;
        state_nxt = state;
        ret_nxt   = ret;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        is_cmd    = 1'b0;
        tgt       = ST_READY;
        gap       = 1;
        unique case (state)
            ST_PWR_WAIT: if (tmr_zero) begin
                state_nxt = ST_NOP_WAIT;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(NOP_CYC - 1);
            end
            ST_NOP_WAIT:    if (tmr_zero) state_nxt = ST_PRE_FIRST;
            ST_PRE_FIRST:   begin is_cmd = 1'b1; tgt = ST_LD_EMR2;     gap = RPA_CYC; end
            ST_LD_EMR2:     begin is_cmd = 1'b1; tgt = ST_LD_EMR3;     gap = MRD_CYC; end
            ST_LD_EMR3:     begin is_cmd = 1'b1; tgt = ST_LD_EMR_DLL;  gap = MRD_CYC; end
            ST_LD_EMR_DLL:  begin is_cmd = 1'b1; tgt = ST_LD_MR_RST;   gap = MRD_CYC; end
            ST_LD_MR_RST:   begin is_cmd = 1'b1; tgt = ST_PRE_SECOND;  gap = MRD_CYC; end
            ST_PRE_SECOND:  begin is_cmd = 1'b1; tgt = ST_REFRESH;     gap = RPA_CYC; end
            ST_REFRESH: begin
                is_cmd = 1'b1;
                gap    = RFC_CYC;
                tgt    = (ref_cnt == RC_W'(REF_COUNT - 1)) ? ST_LD_MR : ST_REFRESH;
            end
            ST_LD_MR:       begin is_cmd = 1'b1; tgt = ST_LD_OCD_DFLT; gap = MRD_CYC; end
            ST_LD_OCD_DFLT: begin is_cmd = 1'b1; tgt = ST_LD_OCD_EXIT; gap = MRD_CYC; end
            ST_LD_OCD_EXIT: begin is_cmd = 1'b1; tgt = ST_READY;       gap = MRD_CYC; end
            ST_GAP:         if (tmr_zero) state_nxt = ret;
            ST_READY:       state_nxt = ST_READY;
            default:        state_nxt = ST_PWR_WAIT;
        endcase
        if (is_cmd) begin
            if (gap > 1) begin
                state_nxt = ST_GAP;
                ret_nxt   = tgt;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(gap - 2);
            end else begin
                state_nxt = tgt;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_PWR_WAIT;
            ret     <= ST_PWR_WAIT;
            ref_cnt <= '0;
        end else begin
            state   <= state_nxt;
            ret     <= ret_nxt;
            if (state == ST_REFRESH) ref_cnt <= ref_cnt + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cke          <= 1'b0;
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            ba           <= '0;
            addr         <= '0;
            init_done    <= 1'b0;
            read_allowed <= 1'b0;
        end else begin
            cke          <= !(state == ST_PWR_WAIT || state == ST_NOP_WAIT);
            {cs_n, ras_n, cas_n, we_n} <= enc_cmd;
            ba           <= enc_ba;
            addr         <= enc_addr;
            init_done    <= (state == ST_READY);
            read_allowed <= (state == ST_READY) && dll_elapsed;
        end
    end

    assign odt = 1'b0;

    AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);  // R2
    AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |-> cke);  // R3
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);  // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP && addr == '0));  // R9
    AST_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        read_allowed |-> init_done);  // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!cke && !init_done && !read_allowed));  // R12

endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;

    localparam int ROW_W = 14;
    localparam int PWR   = 10;
    localparam int NOPC  = 4;
    localparam int RPA   = 3;
    localparam int MRD   = 2;
    localparam int RFC   = 5;
    localparam int DLL   = 40;
    localparam int REFN  = 3;
    localparam int TAIL  = 25;

    typedef struct {
        bit              cke;
        bit [3:0]        cmd;
        bit [1:0]        ba;
        bit [ROW_W-1:0]  addr;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ROW_W-1:0] mr_cfg, emr_cfg, emr2_cfg, emr3_cfg;
    logic cke, odt, cs_n, ras_n, cas_n, we_n, init_done, read_allowed;
    logic [1:0] ba;
    logic [ROW_W-1:0] addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    exp_t model[$];
    int rst_idx;

    always #5 clk = ~clk;

    ddr2_init_seq #(
        .ROW_W(ROW_W), .BA_W(2), .PWR_CYC(PWR), .NOP_CYC(NOPC), .RPA_CYC(RPA),
        .MRD_CYC(MRD), .RFC_CYC(RFC), .DLL_CYC(DLL), .REF_COUNT(REFN)
    ) dut (
        .clk(clk), .rst(rst), .mr_cfg(mr_cfg), .emr_cfg(emr_cfg), .emr2_cfg(emr2_cfg),
        .emr3_cfg(emr3_cfg), .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done),
        .read_allowed(read_allowed)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void put(bit k, bit [3:0] c, bit [1:0] b, bit [ROW_W-1:0] a, string t);
        exp_t e;
        e.cke = k; e.cmd = c; e.ba = b; e.addr = a; e.tag = t;
        model.push_back(e);
    endfunction

    function automatic void pad(int n);
        for (int i = 0; i < n - 1; i++) put(1, 4'b0111, 0, 0, "R5 R9");
    endfunction

    function automatic void build();
        bit [ROW_W-1:0] emr_ok;
        emr_ok = emr_cfg & ~(ROW_W'(14'h0381));         // R7: bits 9:7 and 0 cleared
        model.delete();
        for (int i = 0; i < PWR + NOPC; i++) put(0, 4'b0111, 0, 0, "R2");
        put(1, 4'b0010, 0, ROW_W'(1 << 10), "R3");  pad(RPA);
        put(1, 4'b0000, 2'b10, emr2_cfg, "R4");     pad(MRD);
        put(1, 4'b0000, 2'b11, emr3_cfg, "R4");     pad(MRD);
        put(1, 4'b0000, 2'b01, emr_ok, "R7");       pad(MRD);
        rst_idx = model.size();
        put(1, 4'b0000, 2'b00, mr_cfg | ROW_W'(1 << 8), "R6");  pad(MRD);
        put(1, 4'b0010, 0, ROW_W'(1 << 10), "R4");  pad(RPA);
        for (int r = 0; r < REFN; r++) begin
            put(1, 4'b0001, 0, 0, "R8");            pad(RFC);
        end
        put(1, 4'b0000, 2'b00, mr_cfg & ~ROW_W'(1 << 8), "R6");  pad(MRD);
        put(1, 4'b0000, 2'b01, emr_ok | ROW_W'(14'h0380), "R7"); pad(MRD);
        put(1, 4'b0000, 2'b01, emr_ok, "R7");       pad(MRD + 1);  // R10: done after MRD
        void'(model.pop_back());
    endfunction

    task automatic check_reset_state(string req);
        chk(req, "cke", cke, 0);
        chk(req, "odt", odt, 0);
        chk(req, "cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(req, "ba", ba, 0);
        chk(req, "addr", addr, 0);
        chk(req, "init_done", init_done, 0);
        chk(req, "read_allowed", read_allowed, 0);
    endtask

    // runs the sequence from reset release; stops early when abort_at >= 0
    task automatic run_pass(int abort_at);
        int n;
        build();
        n = model.size();
        for (int j = 0; j < n + TAIL; j++) begin
            bit       e_done;
            bit       e_rd;
            exp_t     e;
            if (j == abort_at) return;
            @(posedge clk);
            @(negedge clk);
            if (j < n) e = model[j];
            else begin
                e.cke = 1; e.cmd = 4'b0111; e.ba = 0; e.addr = 0; e.tag = "R9";
            end
            e_done = (j >= n);
            e_rd   = e_done && (j - rst_idx >= DLL);
            chk(e.tag, "cke", cke, e.cke);
            chk(e.tag, "cmd", {cs_n, ras_n, cas_n, we_n}, e.cmd);
            chk(e.tag, "ba", ba, e.ba);
            chk(e.tag, "addr", addr, e.addr);
            chk("R13", "odt", odt, 0);
            chk("R10", "init_done", init_done, e_done);
            chk("R11", "read_allowed", read_allowed, e_rd);
        end
    endtask

    initial begin
        #(10 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // pattern 1: every configuration bit set
        mr_cfg = '1; emr_cfg = '1; emr2_cfg = '1; emr3_cfg = '1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst = 1'b0;
        run_pass(-1);
        // restart and abort during the refresh phase
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("R1");
        rst = 1'b0;
        run_pass(PWR + NOPC + 20);
        @(negedge clk);
        rst = 1'b1;
        mr_cfg = 14'h0a52; emr_cfg = 14'h1046; emr2_cfg = 14'h0081; emr3_cfg = 14'h2404;
        @(negedge clk);
        check_reset_state("R12");
        @(negedge clk);
        check_reset_state("R12");
        rst = 1'b0;
        // pattern 2: sparse, per-register distinct values; full rerun (R12)
        run_pass(-1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule